// File: doc/BRIEF.md
# Saturating PC-Sampling Profiler

This block watches the program counter of retiring instructions and builds a histogram of where execution time is spent. Every strobe on the retire input advances a local count. When that count reaches the programmed sampling period, one sample is taken. The word-aligned PC (PC bit 0 and bit 1 dropped) then selects a 16-bit bin in an internal counter store, and that bin is incremented. Any count beyond the period carries into the next interval, so sampling stays periodic on average even when the period changes.

Samples whose bin index falls outside the store are discarded. Bins stop counting just below the full 16-bit range. Each bin update is a read-modify-write that spans two cycles. A second sample for a bin whose write is still pending reads the pending value, so back-to-back hits are never lost. The block also keeps a running total of retired instructions, and a cycle total that grows by the period at every sample.

A host reads bins through a valid/ready request channel and a valid/ready response channel. The request carries a bin index. A response, once raised, holds its data until the host accepts it, and no new request is accepted while a response is stalled. A clear pulse starts a sweep that zeroes one bin per cycle. During the sweep, requests are refused and samples are dropped. A sticky done flag is raised when the sweep ends.

Top module: `pc_profiler`

## Requirements
- R1: `inst_total` rises by exactly one on each clock edge where `retire_valid` is high, and neither total changes on an edge where it is low.
- R2: Each retire adds one to a local count. A sample is taken on the retire where the count reaches the effective period. A programmed period of 0 behaves as a period of 1.
- R3: A sample lowers the local count by the effective period, so the excess carries over, and adds the effective period to `cycle_total`.
- R4: While `prof_en` is low, the effective period is all ones (2^PER_W-1), so at most one sample occurs per 2^PER_W-1 retires. The local count and `inst_total` keep advancing.
- R5: The bin index of a sample is `retire_pc >> 2`, so PC bits 1:0 do not affect the choice of bin. A sample whose index is 2^BIN_LOG or more changes no bin.
- R6: A bin is incremented only while its value is below 65000, so it saturates at 65000.
- R7: Samples that hit the same bin on consecutive cycles are all counted. No increment is lost while a write is pending.
- R8: A pulse on `clr_start` while the block is idle holds `clr_busy` high for exactly 2^BIN_LOG cycles and zeroes every bin. `req_ready` is low during the sweep, and samples taken during the sweep change no bin. When the sweep ends, `clr_done` goes high and stays high until the next clear.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. The response data is the bin value at acceptance. `rsp_valid` and `rsp_data` hold while `rsp_ready` is low, and `req_ready` is low while a response is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid | input | 1 | One instruction retires this cycle |
| retire_pc | input | PC_W | PC of the retiring instruction |
| prof_en | input | 1 | Sampling enable |
| period | input | PER_W | Sampling period in retires |
| clr_start | input | 1 | Pulse to start the bin-clear sweep |
| clr_busy | output | 1 | Sweep in progress |
| clr_done | output | 1 | Sticky: last sweep finished |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Request can be accepted |
| req_idx | input | BIN_LOG | Bin to read |
| rsp_valid | output | 1 | Response data valid |
| rsp_ready | input | 1 | Host accepts response |
| rsp_data | output | 16 | Bin value |
| inst_total | output | CNT_W | Retired-instruction total |
| cycle_total | output | CNT_W | Sum of periods over all samples |

## Verification
The bench is built with a 64-bin store. It runs PC sweeps that cover every bin, go past the top of the store, vary the two low PC bits and repeat the same PC back to back. These sweeps are run under periods 0, 1, 2, 3 and 7, and after each one every bin is compared with an arithmetic model. Period 1 with repeated PCs tests the forwarding of pending writes. The odd periods test the carry of the excess count, and the out-of-range PCs test the drop rule. Further runs drive retires with sampling disabled, retire long enough to reach saturation on one bin, start a clear with samples in flight, and stall a read response. These separate the idle period, the limit, the sweep's suppression and length, and the hold rules of the response channel.

// File: rtl/prof_pkg.sv
package prof_pkg;
  localparam int unsigned BIN_W     = 16;
  localparam int unsigned SAT_LIMIT = 65000;
  typedef logic [BIN_W-1:0] bin_t;
endpackage

// File: rtl/prof_sampler.sv
module prof_sampler #(
  parameter int PC_W    = 16,
  parameter int PER_W   = 16,
  parameter int CNT_W   = 32,
  parameter int BIN_LOG = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_valid,
  input  logic [PC_W-1:0]    retire_pc,
  input  logic               prof_en,
  input  logic [PER_W-1:0]   period,
  output logic               smp_valid,
  output logic [BIN_LOG-1:0] smp_idx,
  output logic [CNT_W-1:0]   inst_total,
  output logic [CNT_W-1:0]   cycle_total
);
  localparam int IDX_W = PC_W - 2;

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] eff_per;
  logic [PER_W:0]   cnt_nxt;
  logic             hit;
  logic [IDX_W-1:0] pc_idx;
  logic             in_range;

  always_comb begin
    if (!prof_en)          eff_per = '1;
    else if (period == '0) eff_per = PER_W'(1);
    else                   eff_per = period;
  end

  assign cnt_nxt  = {1'b0, cnt_q} + (PER_W+1)'(1);
  assign hit      = cnt_nxt >= {1'b0, eff_per};
  assign pc_idx   = retire_pc[PC_W-1:2];
  assign in_range = (pc_idx >> BIN_LOG) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      inst_total  <= '0;
      cycle_total <= '0;
      smp_valid   <= 1'b0;
      smp_idx     <= '0;
    end else begin
      smp_valid <= retire_valid && hit && in_range;
      smp_idx   <= pc_idx[BIN_LOG-1:0];
      if (retire_valid) begin
        inst_total <= inst_total + CNT_W'(1);
        if (hit) begin
          cnt_q       <= PER_W'(cnt_nxt - {1'b0, eff_per});
          cycle_total <= cycle_total + CNT_W'(eff_per);
        end else begin
          cnt_q <= cnt_nxt[PER_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/prof_bins.sv
module prof_bins
  import prof_pkg::*;
#(
  parameter int BIN_LOG = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [BIN_LOG-1:0] smp_idx,
  input  logic               clr_start,
  input  logic [BIN_LOG-1:0] rd_idx,
  output bin_t               rd_data,
  output logic               clr_busy,
  output logic               clr_done
);
  localparam int NBINS = 1 << BIN_LOG;

  bin_t               mem [NBINS];
  logic               pend_v;
  logic [BIN_LOG-1:0] pend_idx;
  bin_t               pend_val;
  bin_t               cur;
  bin_t               inc;
  logic [BIN_LOG-1:0] sweep_ptr;

  assign cur     = (pend_v && pend_idx == smp_idx) ? pend_val : mem[smp_idx];
  assign inc     = (cur < BIN_W'(SAT_LIMIT)) ? cur + BIN_W'(1) : cur;
  assign rd_data = (pend_v && pend_idx == rd_idx) ? pend_val : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      pend_val  <= '0;
      clr_busy  <= 1'b0;
      clr_done  <= 1'b0;
      sweep_ptr <= '0;
      for (int i = 0; i < NBINS; i++) mem[i] <= '0;
    end else begin
      pend_v   <= smp_valid && !clr_busy && !clr_start;
      pend_idx <= smp_idx;
      pend_val <= inc;

      if (clr_busy)    mem[sweep_ptr] <= '0;
      else if (pend_v) mem[pend_idx]  <= pend_val;

      if (clr_start && !clr_busy) begin
        clr_busy  <= 1'b1;
        clr_done  <= 1'b0;
        sweep_ptr <= '0;
      end else if (clr_busy) begin
        sweep_ptr <= sweep_ptr + BIN_LOG'(1);
        if (sweep_ptr == BIN_LOG'(NBINS - 1)) begin
          clr_busy <= 1'b0;
          clr_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pc_profiler.sv
module pc_profiler
  import prof_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int PER_W   = 16,
  parameter int CNT_W   = 32,
  parameter int BIN_LOG = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_valid,
  input  logic [PC_W-1:0]    retire_pc,
  input  logic               prof_en,
  input  logic [PER_W-1:0]   period,
  input  logic               clr_start,
  output logic               clr_busy,
  output logic               clr_done,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BIN_LOG-1:0] req_idx,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BIN_W-1:0]   rsp_data,
  output logic [CNT_W-1:0]   inst_total,
  output logic [CNT_W-1:0]   cycle_total
);
  logic               smp_valid;
  logic [BIN_LOG-1:0] smp_idx;
  bin_t               rd_data;

  prof_sampler #(
    .PC_W(PC_W), .PER_W(PER_W), .CNT_W(CNT_W), .BIN_LOG(BIN_LOG)
  ) u_sampler (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid),
    .retire_pc(retire_pc), .prof_en(prof_en), .period(period),
    .smp_valid(smp_valid), .smp_idx(smp_idx),
    .inst_total(inst_total), .cycle_total(cycle_total)
  );

  prof_bins #(.BIN_LOG(BIN_LOG)) u_bins (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_idx(smp_idx),
    .clr_start(clr_start), .rd_idx(req_idx), .rd_data(rd_data),
    .clr_busy(clr_busy), .clr_done(clr_done)
  );

  assign req_ready = !clr_busy && (!rsp_valid || rsp_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prof_checker.sv
module prof_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire_valid,
  input logic             clr_busy,
  input logic             clr_done,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [15:0]      rsp_data,
  input logic [CNT_W-1:0] inst_total,
  input logic [CNT_W-1:0] cycle_total
);
  AST_INST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> inst_total == $past(inst_total) + CNT_W'(1)); // R1
  AST_IDLE_TOTALS: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_valid |=> $stable(inst_total) && $stable(cycle_total)); // R1
  AST_BIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data <= 16'd65000); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R9
  AST_SWEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !req_ready); // R8
  AST_SWEEP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_busy) |-> clr_done); // R8
endmodule

bind pc_profiler prof_checker #(.CNT_W(CNT_W)) u_prof_checker (
  .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid),
  .clr_busy(clr_busy), .clr_done(clr_done), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .inst_total(inst_total), .cycle_total(cycle_total)
);

// File: tb/test_pc_profiler.sv
module test_pc_profiler;
  localparam int PC_W = 16, PER_W = 16, CNT_W = 32, BL = 6, NB = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic retire_valid = 1'b0, prof_en = 1'b0, clr_start = 1'b0;
  logic [PC_W-1:0] retire_pc = '0;
  logic [PER_W-1:0] period = '0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [BL-1:0] req_idx = '0;
  logic clr_busy, clr_done, req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [CNT_W-1:0] inst_total, cycle_total;

  int checks = 0, errors = 0;
  int mdl [NB];
  int mcnt = 0, minst = 0, mcyc = 0;
  bit mclr = 1'b0;
  int busy_cnt = 0;

  always #5 clk = ~clk;

  pc_profiler #(.PC_W(PC_W), .PER_W(PER_W), .CNT_W(CNT_W), .BIN_LOG(BL)) i_pc_profiler (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .prof_en(prof_en), .period(period), .clr_start(clr_start),
    .clr_busy(clr_busy), .clr_done(clr_done), .req_valid(req_valid),
    .req_ready(req_ready), .req_idx(req_idx), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .inst_total(inst_total), .cycle_total(cycle_total)
  );

  always @(negedge clk) if (clr_busy) busy_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic retire(input logic [PC_W-1:0] pc);
    int eff, n;
    retire_valid = 1'b1;
    retire_pc = pc;
    eff = !prof_en ? 65535 : (period == 0 ? 1 : int'(period));
    n = mcnt + 1;
    minst++;
    if (n >= eff) begin
      mcnt = n - eff;
      mcyc += eff;
      if ((int'(pc) >> 2) < NB && !mclr && mdl[int'(pc) >> 2] < 65000)
        mdl[int'(pc) >> 2]++;
    end else mcnt = n;
    @(posedge clk);
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  task automatic read_bin(input int idx, output int v);
    req_valid = 1'b1;
    req_idx = BL'(idx);
    rsp_ready = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    v = int'(rsp_data);
  endtask

  task automatic check_all(input string tag);
    int v;
    for (int i = 0; i < NB; i++) begin
      read_bin(i, v);
      chk(v == mdl[i], tag, v, mdl[i]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, d;
    int pers [5] = '{1, 2, 3, 7, 0};
    for (int i = 0; i < NB; i++) mdl[i] = 0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(inst_total == 0, "R1 reset inst_total", int'(inst_total), 0);
    chk(cycle_total == 0, "R3 reset cycle_total", int'(cycle_total), 0);
    chk(!clr_busy && !clr_done, "R8 reset clear flags", int'(clr_done), 0);
    read_bin(0, v);
    chk(v == 0, "R6 reset bin", v, 0);

    // R2 R3 R5 R7: sweeps per period, repeated PCs and out-of-range PCs
    prof_en = 1'b1;
    foreach (pers[p]) begin
      period = PER_W'(pers[p]);
      for (int k = 0; k < 90; k++) begin
        for (int r = 0; r <= k % 3; r++)
          retire(PC_W'((k * 4 + (k % 4)) % 360));
      end
      idle(4);
      check_all(pers[p] == 1 ? "R7 bin after back-to-back" :
                pers[p] == 0 ? "R2 bin period zero" : "R5 bin after sweep");
      chk(int'(inst_total) == minst, "R1 inst_total", int'(inst_total), minst);
      chk(int'(cycle_total) == mcyc, "R3 cycle_total", int'(cycle_total), mcyc);
    end

    // R4: disabled sampling
    prof_en = 1'b0;
    for (int k = 0; k < 30; k++) retire(PC_W'(0));
    idle(4);
    read_bin(0, v);
    chk(v == mdl[0], "R4 bin while disabled", v, mdl[0]);
    chk(int'(cycle_total) == mcyc, "R4 cycle_total while disabled", int'(cycle_total), mcyc);
    chk(int'(inst_total) == minst, "R4 inst_total while disabled", int'(inst_total), minst);

    // R8: clear sweep with samples during it
    prof_en = 1'b1;
    period = PER_W'(1);
    busy_cnt = 0;
    clr_start = 1'b1;
    @(negedge clk);
    clr_start = 1'b0;
    chk(clr_busy && !req_ready, "R8 busy blocks requests", int'(req_ready), 0);
    mclr = 1'b1;
    for (int k = 0; k < 5; k++) retire(PC_W'(4));
    while (clr_busy) @(negedge clk);
    mclr = 1'b0;
    for (int i = 0; i < NB; i++) mdl[i] = 0;
    chk(busy_cnt == NB, "R8 sweep length", busy_cnt, NB);
    chk(clr_done == 1'b1, "R8 done flag", int'(clr_done), 1);
    idle(2);
    check_all("R8 bin after clear");
    chk(clr_done == 1'b1, "R8 done sticky", int'(clr_done), 1);

    // R9: stalled response
    retire(PC_W'(8));
    idle(4);
    req_valid = 1'b1;
    req_idx = BL'(2);
    rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = int'(rsp_data);
    chk(d == mdl[2], "R9 response data", d, mdl[2]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && int'(rsp_data) == d && !req_ready, "R9 response held", int'(rsp_data), d);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R9 response released", int'(rsp_valid), 0);

    // R6: saturation
    for (int k = 0; k < 65010; k++) retire(PC_W'(32));
    for (int k = 0; k < 5; k++) retire(PC_W'(36));
    idle(4);
    read_bin(8, v);
    chk(v == 65000, "R6 saturated bin", v, 65000);
    read_bin(9, v);
    chk(v == mdl[9], "R6 neighbour bin", v, mdl[9]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule